// File: doc/BRIEF.md
# Register-Mapped 32-Pin GPIO Bank with Half-Word Masked Writes

This block gives software control of 32 general-purpose pins through a plain register bus that has an address, a write strobe with write data, and a read strobe with read data. Every pin has three control bits: an output value, a direction bit and a drive-enable bit. A pin's pad driver is on only when its direction bit and its drive-enable bit are both 1. The pad output value always comes from the output value register.

Software can load all 32 output bits in one write. It can also change part of one 16-bit half without first reading it back, through two masked-write registers. In these registers the upper 16 bits of the written word select which bits are protected, and the lower 16 bits carry the new values. A read-only register returns the pin levels after a two-flop synchroniser. When a pin is driving, that register therefore returns the value the block puts on the pin.

The block is used next to a pad ring. `pad_out` and `pad_oe` feed each tri-state pad, and the pad's input buffer returns on `pad_in`.

Top module: `gpio_bank`

## Requirements
- R1: The reset is synchronous and active low. While `rst_n` is 0 at a rising edge, the output value, direction and drive-enable registers clear to 0. `pad_out` and `pad_oe` are therefore 0 after that edge, and reads of 0x040, 0x204 and 0x208 return 0.
- R2: A write to 0x040 loads all 32 output bits from the write data. A read of 0x040 returns the last value loaded, whatever the levels on `pad_in`.
- R3: A write to 0x000 changes only output bits 15:0. For each bit i from 0 to 15: if write-data bit 16+i is 0, output bit i takes write-data bit i; if write-data bit 16+i is 1, output bit i keeps its value. Output bits 31:16 do not change. For example, 0xFF7F0080 sets only bit 7 to 1.
- R4: A write to 0x004 applies the same masked rule to output bits 31:16. Write-data bits 15:0 give the new values and write-data bits 31:16 give the per-bit mask. Output bits 15:0 do not change.
- R5: For each pin i, `pad_oe[i]` equals direction bit i AND drive-enable bit i, and `pad_out[i]` equals output bit i. Both follow a register write from the first rising edge after it.
- R6: The direction register at 0x204 and the drive-enable register at 0x208 are loaded by full-word writes and read back as written.
- R7: A read of 0x060 returns `pad_in` through a two-flop synchroniser. A pin level applied before rising edge n appears in a read sampled at edge n+2 or later. A read sampled at edge n or n+1 still returns the old level.
- R8: Writes to 0x060 and to any unmapped address change no register. Reads of 0x000, 0x004 and any unmapped address return 0.
- R9: Read data is registered. `bus_rdata` takes the addressed value at the rising edge where `bus_rd` is 1 and holds that value while `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Levels seen at the pads |
| pad_out | output | 32 | Output value to each pad |
| pad_oe | output | 32 | Pad drive enable, 1 drives |

## Verification
A write takes effect at the rising edge where the strobe is sampled, so `pad_out` and `pad_oe` are compared half a cycle after that edge. Read data is registered and belongs to the same edge as its strobe, so every read is compared at the falling edge that follows it. The pin register adds two edges of synchroniser delay. The bench therefore changes a pin level and then issues three reads in a row: the first two must return the old level and the third must return the new one. This pins the lag to exactly two edges, not merely at most two.

// File: rtl/gpio_bank_pkg.sv
// gpio_bank_pkg: the register offsets, the decoded register selector and
// the decode function that the GPIO bank uses.
// Assumes a 12-bit byte address and a 32-bit data bus.
package gpio_bank_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_LO_MASK = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_HI_MASK = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_OUTVAL  = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_PINS    = 12'h060;
    localparam logic [ADDR_W-1:0] OFS_DIR     = 12'h204;
    localparam logic [ADDR_W-1:0] OFS_DRVEN   = 12'h208;

    typedef enum logic [2:0] {
        SEL_NONE    = 3'd0,
        SEL_LO_MASK = 3'd1,
        SEL_HI_MASK = 3'd2,
        SEL_OUTVAL  = 3'd3,
        SEL_PINS    = 3'd4,
        SEL_DIR     = 3'd5,
        SEL_DRVEN   = 3'd6
    } reg_sel_e;

    // Map a byte offset to a register selector; unmapped offsets give SEL_NONE.
    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] ofs);
        reg_sel_e sel;
        case (ofs)
            OFS_LO_MASK: sel = SEL_LO_MASK;
            OFS_HI_MASK: sel = SEL_HI_MASK;
            OFS_OUTVAL:  sel = SEL_OUTVAL;
            OFS_PINS:    sel = SEL_PINS;
            OFS_DIR:     sel = SEL_DIR;
            OFS_DRVEN:   sel = SEL_DRVEN;
            default:     sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/gpio_bank_ctrl_regs.sv
// gpio_bank_ctrl_regs: holds the output value, direction and drive-enable
// registers. The output value is split into lanes of LANE_W bits. Each lane
// can be loaded by a full-word write or by its own masked-write register.
// Assumes PINS == DATA_W and exactly two lanes, so that the mask and the new
// values of one lane fit together in one data word.
module gpio_bank_ctrl_regs
    import gpio_bank_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [PINS-1:0]   outval_q,
    output logic [PINS-1:0]   dir_q,
    output logic [PINS-1:0]   drven_q
);

    localparam int LANE_W = PINS / 2;
    localparam int LANES  = 2;

    logic [LANE_W-1:0] lane_mask;
    logic [LANE_W-1:0] lane_new;

    // Split a masked-write word into its mask half and its new-value half.
    always_comb begin
        lane_mask = wdata[DATA_W-1 -: LANE_W];
        lane_new  = wdata[LANE_W-1:0];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam reg_sel_e LANE_SEL = (g == 0) ? SEL_LO_MASK : SEL_HI_MASK;

        logic [LANE_W-1:0] lane_q;

        // Update one lane: a full-word load, or a masked merge in which a mask bit of 1 keeps the old value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else if (wr_en && sel == SEL_OUTVAL) begin
                lane_q <= wdata[g*LANE_W +: LANE_W];
            end else if (wr_en && sel == LANE_SEL) begin
                lane_q <= (lane_q & lane_mask) | (lane_new & ~lane_mask);
            end
        end

        assign outval_q[g*LANE_W +: LANE_W] = lane_q;
    end

    // Load the direction register from a full-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr_en && sel == SEL_DIR) begin
            dir_q <= wdata[PINS-1:0];
        end
    end

    // Load the drive-enable register from a full-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drven_q <= '0;
        end else if (wr_en && sel == SEL_DRVEN) begin
            drven_q <= wdata[PINS-1:0];
        end
    end

endmodule

// File: rtl/gpio_bank_pin_sync.sv
// gpio_bank_pin_sync: a separate chain of STAGES flops for each pin, to bring
// the asynchronous pad levels into the clock domain. Assumes STAGES >= 2.
// The chains clear to 0 on reset.
module gpio_bank_pin_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    for (genvar p = 0; p < W; p++) begin : g_pin
        logic [STAGES-1:0] chain_q;

        // Shift the pad level one stage deeper on every clock.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_in[p]};
            end
        end

        assign sync_out[p] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/gpio_bank_read_mux.sv
// gpio_bank_read_mux: picks the addressed register for a read and registers
// it. bus_rdata changes only at an edge where the read strobe is sampled.
// The masked-write registers and unmapped offsets read as zero.
module gpio_bank_read_mux
    import gpio_bank_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  reg_sel_e          sel,
    input  logic [PINS-1:0]   outval_q,
    input  logic [PINS-1:0]   dir_q,
    input  logic [PINS-1:0]   drven_q,
    input  logic [PINS-1:0]   pins_sync,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] rd_next;

    // Select the value of the addressed register.
    always_comb begin
        rd_next = '0;
        case (sel)
            SEL_OUTVAL: rd_next[PINS-1:0] = outval_q;
            SEL_PINS:   rd_next[PINS-1:0] = pins_sync;
            SEL_DIR:    rd_next[PINS-1:0] = dir_q;
            SEL_DRVEN:  rd_next[PINS-1:0] = drven_q;
            default:    rd_next = '0;
        endcase
    end

    // Capture the selected value on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_next;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
// gpio_bank: top level of the 32-pin GPIO bank. It decodes the bus offset,
// holds the control registers, synchronises the pad inputs and drives the
// pad controls. A pad drives only when its direction bit and its
// drive-enable bit are both set. Assumes a single-cycle bus with no wait
// states and at most one access per cycle.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int PINS        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);

    reg_sel_e        sel;
    logic [PINS-1:0] outval_q;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] drven_q;
    logic [PINS-1:0] pins_sync;

    // Decode the bus offset once for both the write path and the read path.
    always_comb begin
        sel = decode_offset(bus_addr);
    end

    gpio_bank_ctrl_regs #(
        .PINS (PINS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .sel      (sel),
        .wdata    (bus_wdata),
        .outval_q (outval_q),
        .dir_q    (dir_q),
        .drven_q  (drven_q)
    );

    gpio_bank_pin_sync #(
        .W      (PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pins_sync)
    );

    gpio_bank_read_mux #(
        .PINS (PINS)
    ) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (bus_rd),
        .sel       (sel),
        .outval_q  (outval_q),
        .dir_q     (dir_q),
        .drven_q   (drven_q),
        .pins_sync (pins_sync),
        .rdata     (bus_rdata)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pad
        // Each pad takes its output bit, and drives only when both control bits are 1.
        assign pad_out[p] = outval_q[p];
        assign pad_oe[p]  = dir_q[p] & drven_q[p];
    end

endmodule

// File: rtl/gpio_bank_checker.sv
// gpio_bank_checker: properties over the GPIO bank ports, attached to every
// instance of gpio_bank by the bind statement at the end of this file.
module gpio_bank_checker
    import gpio_bank_pkg::*;
#(
    parameter int PINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe
);

    localparam int LW = PINS / 2;

    logic mapped_out_wr;

    // Flag writes that may change the output value register.
    always_comb begin
        mapped_out_wr = bus_wr && (bus_addr == OFS_OUTVAL || bus_addr == OFS_LO_MASK ||
                                   bus_addr == OFS_HI_MASK);
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pad_out == '0 && pad_oe == '0));

    assert_full_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_OUTVAL) |=> pad_out == $past(bus_wdata[PINS-1:0]));

    assert_low_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_LO_MASK) |=>
            (pad_out[PINS-1:LW] == $past(pad_out[PINS-1:LW]) &&
             pad_out[LW-1:0] == (($past(pad_out[LW-1:0]) & $past(bus_wdata[DATA_W-1 -: LW])) |
                                 ($past(bus_wdata[LW-1:0]) & ~$past(bus_wdata[DATA_W-1 -: LW])))));

    assert_high_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_HI_MASK) |=>
            (pad_out[LW-1:0] == $past(pad_out[LW-1:0]) &&
             pad_out[PINS-1:LW] == (($past(pad_out[PINS-1:LW]) & $past(bus_wdata[DATA_W-1 -: LW])) |
                                    ($past(bus_wdata[LW-1:0]) & ~$past(bus_wdata[DATA_W-1 -: LW])))));

    assert_dir_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIR && bus_wdata == '0) |=> pad_oe == '0);

    assert_drven_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DRVEN && bus_wdata == '0) |=> pad_oe == '0);

    assert_other_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped_out_wr |=> $stable(pad_out));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpio_bank gpio_bank_checker #(
    .PINS (PINS)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_bank_bench.sv
`timescale 1ns/1ps
// gpio_bank_bench: directed bench for gpio_bank. Every scenario task
// starts just after a falling edge and checks its own results.
module gpio_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [31:0] ext_val = '0;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Pad model: a driving pad shows its own output, otherwise the external level.
    assign pad_in = (pad_out & pad_oe) | (ext_val & ~pad_oe);

    gpio_bank u_gpio_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        bus_read(12'h040, v); check("R1 outval", v, 32'h0);
        bus_read(12'h204, v); check("R1 dir", v, 32'h0);
        bus_read(12'h208, v); check("R1 drven", v, 32'h0);
        bus_write(12'h040, 32'hFFFF_FFFF);
        bus_write(12'h204, 32'hFFFF_FFFF);
        bus_write(12'h208, 32'hFFFF_FFFF);
        check("R1 setup oe", pad_oe, 32'hFFFF_FFFF);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 mid reset pad_out", pad_out, 32'h0);
        check("R1 mid reset pad_oe", pad_oe, 32'h0);
        bus_read(12'h204, v); check("R1 mid reset dir", v, 32'h0);
    endtask

    task automatic t_full_load;
        logic [31:0] v;
        ext_val = 32'h0F0F_0F0F;
        bus_write(12'h040, 32'hDEAD_BEEF);
        check("R2 pad_out", pad_out, 32'hDEAD_BEEF);
        bus_read(12'h040, v); check("R2 readback", v, 32'hDEAD_BEEF);
        bus_write(12'h040, 32'h1357_9BDF);
        bus_read(12'h040, v); check("R2 readback 2", v, 32'h1357_9BDF);
    endtask

    task automatic t_low_masked;
        logic [31:0] v;
        bus_write(12'h040, 32'hA5A5_5A5A);
        bus_write(12'h000, 32'hFF7F_0080);
        check("R3 single bit 7", pad_out, 32'hA5A5_5ADA);
        bus_write(12'h000, 32'h0000_1234);
        check("R3 open mask", pad_out, 32'hA5A5_1234);
        bus_write(12'h000, 32'hFFFF_0000);
        check("R3 full mask", pad_out, 32'hA5A5_1234);
        bus_write(12'h000, 32'h00FF_ABCD);
        check("R3 keep low byte", pad_out, 32'hA5A5_AB34);
        bus_read(12'h000, v); check("R8 low masked reads 0", v, 32'h0);
    endtask

    task automatic t_high_masked;
        logic [31:0] v;
        bus_write(12'h040, 32'h0000_C3C3);
        bus_write(12'h004, 32'h7FFF_8000);
        check("R4 bit 31", pad_out, 32'h8000_C3C3);
        bus_write(12'h004, 32'h0000_BEEF);
        check("R4 open mask", pad_out, 32'hBEEF_C3C3);
        bus_write(12'h004, 32'hF0F0_0000);
        check("R4 partial mask", pad_out, 32'hB0E0_C3C3);
        bus_read(12'h004, v); check("R8 high masked reads 0", v, 32'h0);
    endtask

    task automatic t_drive;
        logic [31:0] v;
        bus_write(12'h204, 32'hFFFF_0000);
        check("R5 dir only", pad_oe, 32'h0);
        bus_write(12'h208, 32'h00FF_00FF);
        check("R5 and of bits", pad_oe, 32'h00FF_0000);
        bus_read(12'h204, v); check("R6 dir readback", v, 32'hFFFF_0000);
        bus_read(12'h208, v); check("R6 drven readback", v, 32'h00FF_00FF);
        bus_write(12'h204, 32'h0000_0000);
        bus_write(12'h208, 32'h0000_0000);
    endtask

    task automatic t_pins;
        logic [31:0] v;
        ext_val = 32'h0000_0000;
        @(negedge clk); @(negedge clk); @(negedge clk);
        ext_val = 32'hC0DE_F00D;
        bus_read(12'h060, v); check("R7 edge n old", v, 32'h0);
        bus_read(12'h060, v); check("R7 edge n+1 old", v, 32'h0);
        bus_read(12'h060, v); check("R7 edge n+2 new", v, 32'hC0DE_F00D);
        bus_write(12'h060, 32'h1111_1111);
        bus_read(12'h040, v); check("R8 pins write ignored", v, 32'hB0E0_C3C3);
        bus_read(12'h060, v); check("R8 pins unchanged", v, 32'hC0DE_F00D);
        bus_write(12'h040, 32'h5555_AAAA);
        bus_write(12'h204, 32'h0000_FFFF);
        bus_write(12'h208, 32'h0000_FFFF);
        bus_read(12'h060, v);
        bus_read(12'h060, v);
        bus_read(12'h060, v);
        check("R7 driven pins", v, 32'hC0DE_AAAA);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        bus_write(12'h100, 32'hFFFF_FFFF);
        bus_write(12'h044, 32'h0000_0000);
        check("R8 unmapped write pad_out", pad_out, 32'h5555_AAAA);
        check("R8 unmapped write pad_oe", pad_oe, 32'h0000_FFFF);
        bus_read(12'h204, v); check("R8 dir unchanged", v, 32'h0000_FFFF);
        bus_read(12'h100, v); check("R8 unmapped read", v, 32'h0);
    endtask

    task automatic t_read_hold;
        logic [31:0] v;
        bus_read(12'h040, v);
        check("R9 read value", v, 32'h5555_AAAA);
        bus_addr = 12'h204;
        bus_write(12'h040, 32'h0BAD_CAFE);
        @(negedge clk); @(negedge clk);
        check("R9 rdata held", bus_rdata, 32'h5555_AAAA);
        bus_read(12'h040, v);
        check("R9 new read", v, 32'h0BAD_CAFE);
    endtask

    // Watchdog: an expired timer counts as a failed check and still prints the summary.
    initial begin
        #1_000_000;
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Main sequence: reset, then each scenario in turn.
    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_load();
        t_low_masked();
        t_high_masked();
        t_drive();
        t_pins();
        t_unmapped();
        t_read_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule